// File: doc/BRIEF.md
# Field-Transition Hold Pulse Generator

This block produces an active-high pulse that opens a programmable number of half lines before the next vertical sync. Its intended use is holding a clock steady while unstable tape-deck video passes through the field transition. The pulse has to lead the sync, so the block cannot wait for that sync. Instead it counts half lines across each field. It keeps the length of the field that just ended and uses it to predict where the coming sync will fall.

A half-line tick fires on each rising edge of the horizontal blanking strobe. A second tick fires `HALF_CLKS` clocks later, at mid-line. Standard fields contain an odd number of half lines, so the sync lands alternately at line start and at mid-line. Counting half lines keeps the prediction exact in both cases. A 4-bit position code sets the lead as code + 3 half lines. A 4-bit width code sets the high time as 0 to 15 half lines.

Top module: `field_hold_pulse`

## Requirements
- R1: While `rst_n` is low, and after its release until a pulse starts, `hold_o` is 0.
- R2: No pulse occurs until two rising edges of `vsync_i` have been seen after reset, so that one whole field has been measured.
- R3: A tick is one clock with a rising edge of `blank_i`, or the clock exactly `HALF_CLKS` clocks after one. The field length is the number of ticks between two rising edges of `vsync_i`. `hold_o` goes high after the tick that brings the count within the current field to `len - (pos_code + 3)`.
- R4: Once high, `hold_o` falls after the tick that occurs `width_code` ticks after its starting tick.
- R5: With `width_code` = 0 no pulse is produced.
- R6: A rising edge of `vsync_i` forces `hold_o` low on the next clock, even if the width count has not run out.
- R7: The prediction uses the length of the most recently completed field. If the current field ends before the predicted start tick, no pulse appears in that field.
- R8: If the previous field length is not greater than `pos_code + 3`, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank_i | input | 1 | Horizontal blanking strobe; its rising edge marks line start |
| vsync_i | input | 1 | Vertical sync; its rising edge ends a field |
| width_code | input | 4 | Pulse width in half lines (0 to 15) |
| pos_code | input | 4 | Lead before sync, in half lines, minus 3 |
| hold_o | output | 1 | Active-high hold pulse |

## Verification
A wrong latched field length or a drifting half-line count moves the pulse edge by whole half lines. This shows at `hold_o` in the first field that follows the faulty measurement. A mid-line tick that is misplaced or missed shifts the pulse in fields of both parities. The bench checks `hold_o` on every clock against the half-line index it tracks itself. Any such error therefore surfaces at the first half line where the expected and actual pulse differ, within one field.

// File: rtl/field_hold_pulse.sv
module field_hold_pulse #(
  parameter int HALF_CLKS = 432,
  parameter int CNT_W     = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blank_i,
  input  logic       vsync_i,
  input  logic [3:0] width_code,
  input  logic [3:0] pos_code,
  output logic       hold_o
);
  localparam int MW = $clog2(HALF_CLKS + 1);

  logic             blank_q, vsync_q;
  logic [MW-1:0]    mid_cnt;
  logic [CNT_W-1:0] hl_cnt, field_len;
  logic             seen_sync, len_ok;
  logic [3:0]       left;
  logic             hold_q;

  wire line_start = blank_i & ~blank_q;
  wire mid_tick   = (mid_cnt == MW'(HALF_CLKS));
  wire tick       = line_start | mid_tick;
  wire vs_rise    = vsync_i & ~vsync_q;

  wire [CNT_W-1:0] hl_next = (&hl_cnt) ? hl_cnt : hl_cnt + 1'b1;
  wire [CNT_W-1:0] lead    = CNT_W'(pos_code) + CNT_W'(3);
  wire [CNT_W-1:0] target  = field_len - lead;
  wire target_ok = len_ok && (field_len > lead);
  wire start = tick && target_ok && (hl_next == target) && (width_code != 4'd0) && !hold_q;

  assign hold_o = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= 1'b0;
      vsync_q <= 1'b0;
      mid_cnt <= '0;
    end else begin
      blank_q <= blank_i;
      vsync_q <= vsync_i;
      if (line_start)          mid_cnt <= MW'(1);
      else if (mid_tick)       mid_cnt <= '0;
      else if (mid_cnt != '0)  mid_cnt <= mid_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hl_cnt    <= '0;
      field_len <= '0;
      seen_sync <= 1'b0;
      len_ok    <= 1'b0;
    end else if (vs_rise) begin
      hl_cnt    <= '0;
      field_len <= hl_cnt;
      seen_sync <= 1'b1;
      if (seen_sync) len_ok <= 1'b1;
    end else if (tick) begin
      hl_cnt <= hl_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      left   <= '0;
    end else if (vs_rise) begin
      hold_q <= 1'b0;
      left   <= '0;
    end else if (start) begin
      hold_q <= 1'b1;
      left   <= width_code;
    end else if (hold_q && tick) begin
      if (left == 4'd1) hold_q <= 1'b0;
      left <= left - 1'b1;
    end
  end

  AST_NO_EARLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !len_ok |-> !hold_o);  // R2
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> $past(tick));  // R3
  AST_FALL_ON_TICK_OR_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_o) |-> $past(tick || vs_rise));  // R4
  AST_ZERO_WIDTH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (width_code == 4'd0 && !hold_o) |=> !hold_o);  // R5
  AST_SYNC_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> !hold_o);  // R6
endmodule

// File: tb/test_field_hold_pulse.sv
module test_field_hold_pulse;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0, blank_i = 1'b0, vsync_i = 1'b0;
  logic [3:0] width_code = '0, pos_code = '0;
  logic hold_o;

  int checks = 0, bad = 0;
  int c = 0, since = 0, hb = 0, vs_left = 0, nsync = 0, prev_len = 0;
  bit done = 0;

  always #10 clk = ~clk;

  field_hold_pulse #(.HALF_CLKS(H), .CNT_W(10)) i_field_hold_pulse (
    .clk(clk), .rst_n(rst_n), .blank_i(blank_i), .vsync_i(vsync_i),
    .width_code(width_code), .pos_code(pos_code), .hold_o(hold_o));

  function automatic bit exp_hold(int i, int plen, bit pv, int pos, int w);
    int lead, t;
    if (!pv || w == 0) return 0;
    lead = pos + 3;
    if (plen <= lead) return 0;
    t = plen - lead;
    return (i >= t) && (i < t + w);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_field(int len, int pos, int w, string req);
    int mism = 0, first_bad = -1;
    bit pv = (nsync >= 2);
    bit ended = 0;
    width_code = 4'(w);
    pos_code   = 4'(pos);
    while (!ended) begin
      blank_i = (c < 2*H - 2);
      if (c == 0 || c == H) begin hb++; since = 0; end
      else since++;
      if (vs_left > 0) vs_left--;
      if (hb == len && since == 2) begin
        vs_left = 3;
        hb = 0;
        ended = 1;
      end
      vsync_i = (vs_left > 0);
      @(posedge clk);
      @(negedge clk);
      if (hold_o !== exp_hold(hb, prev_len, pv, pos, w)) begin
        mism++;
        if (first_bad < 0) first_bad = hb;
      end
      c = (c + 1) % (2*H);
    end
    if (mism != 0) $display("  mismatch from half line %0d", first_bad);
    check(req, mism, 0);
    prev_len = len;
    nsync++;
  endtask

  initial begin
    int seed = 32'h5EED;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 in reset", hold_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", hold_o, 0);

    run_field(31, 0, 4, "R2 first partial field");
    run_field(41, 0, 4, "R2 measuring field");
    run_field(41, 0, 4, "R3 R4 basic placement");
    run_field(41, 3, 0, "R5 zero width");
    run_field(41, 2, 15, "R6 cut by sync");
    run_field(61, 6, 3, "R7 length change predicted");
    run_field(15, 5, 3, "R7 field ends before target");
    run_field(15, 14, 5, "R8 lead exceeds length");
    run_field(575, 15, 15, "R8 lead exceeds short prev");
    run_field(575, 15, 9, "R3 R4 long field max lead");
    run_field(573, 0, 1, "R3 R4 min lead width one");
    for (int k = 0; k < 30; k++) begin
      int len = 2 * $urandom_range(10, 100) + 1;
      int pos = $urandom_range(0, 15);
      int w   = $urandom_range(0, 15);
      run_field(len, pos, w, "R3 R4 R6 R7 random field");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule